// File: doc/BRIEF.md
# Streaming Page Load Scan Register

This block is a scan data register that looks, from the test access port, like one shift register as long as a flash page. By default that page is 256 bytes, so 2048 bits. Inside it holds only an 8-bit shift register, a 3-bit bit counter and a byte counter. Each time eight bits have been shifted in from `tdi` during Shift-DR, the completed byte is offered on a byte-wide write port into the page buffer. Its address is the next offset in the page. Nothing waits for Update-DR: the data reach the buffer while shifting is still going on.

The TAP controller sits outside the block and drives the state strobes, one clock per TCK edge. Capture-DR restarts a load at page offset 0 and throws away any partial byte. Update-DR moves nothing. This method of loading a page depends on the register being the first device in the scan chain, because the byte boundaries must line up with the host's TDI stream. When that does not hold, the system falls back to a byte-by-byte programming method, which lies outside this block.

The write port follows valid/ready rules with a one-entry holding stage. While `pb_valid` is high and `pb_ready` is low, address and data stay frozen. TCK cannot be stalled, so the consumer has up to eight TCK cycles to accept a byte. If another byte completes while one is still waiting, the new byte is dropped. Its page offset is still used up.

Top module: `vpl_page_load_dr`

## Requirements
- R1: While `rst_n` is low and right after it goes high, `pb_valid` is 0 and `tdo` is 0. The first byte after reset is written to address 0.
- R2: Bits enter LSB first: the first bit shifted into a byte becomes bit 0 of `pb_data`, and the eighth becomes bit 7.
- R3: On the TCK edge that shifts in the eighth bit of a byte, the byte is presented: `pb_valid` is high right after that edge.
- R4: Successive bytes of a load go to addresses 0, 1, 2, … in order.
- R5: An edge with `capture_dr` high resets the bit count, the byte address and the shift register to zero. Bits of a byte that was not finished are discarded.
- R6: Edges with `shift_dr` low do not shift, count or write. This holds whatever `tdi` is, and an `update_dr` pulse causes no transfer.
- R7: Once PAGE_BYTES bytes have been written in a load, further shifted bits produce no write. The address does not wrap.
- R8: While `pb_valid` is high and `pb_ready` is low, `pb_valid`, `pb_addr` and `pb_data` hold steady. A byte completing in that state is dropped, but its address is still consumed.
- R9: `tdo` shows the bit that was shifted in eight shift edges earlier. After Capture-DR it is 0 until eight new bits have been shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| capture_dr | input | 1 | TAP is in Capture-DR for this edge |
| shift_dr | input | 1 | TAP is in Shift-DR for this edge |
| update_dr | input | 1 | TAP is in Update-DR for this edge (no transfer) |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, LSB of the 8-bit shift register |
| pb_valid | output | 1 | Page buffer write offered |
| pb_ready | input | 1 | Page buffer accepts the offered write |
| pb_addr | output | $clog2(PAGE_BYTES) | Byte offset in the page |
| pb_data | output | 8 | Byte to write |

## Verification
A bit counter that is off by one shifts every byte's boundary. At the port this shows up as the wrong `pb_data` on the first write, and the first write arrives one edge early or late. A byte counter that is wrong shows up at once in `pb_addr`, or at the end of a page as a missing write or a 257th write. Faults in the holding stage show in the same cycle as a changed `pb_addr` or `pb_data` while `pb_ready` is low. The bench keeps a cycle-accurate model and compares all outputs on every cycle, so each such fault is reported on the first cycle it becomes visible.

// File: rtl/vpl_pkg.sv
package vpl_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/vpl_deser.sv
module vpl_deser
  import vpl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture_dr,
  input  logic  shift_dr,
  input  logic  tdi,
  output byte_t next_byte,
  output logic  byte_last,
  output logic  tdo
);
  logic [BIT_IDX_W-1:0] bit_q;
  byte_t                sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      sr_q  <= '0;
    end else if (capture_dr) begin
      bit_q <= '0;
      sr_q  <= '0;
    end else if (shift_dr) begin
      sr_q  <= next_byte;
      bit_q <= bit_q + 1'b1;
    end
  end

  always_comb begin
    next_byte = {tdi, sr_q[BYTE_W-1:1]};
    byte_last = shift_dr && !capture_dr && (bit_q == BIT_IDX_W'(BYTE_W-1));
    tdo       = sr_q[0];
  end

  // R5
  capture_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_dr |=> (bit_q == '0) && (sr_q == '0));

  // R9
  msb_takes_tdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && !capture_dr) |=> (sr_q[BYTE_W-1] == $past(tdi)));
endmodule

// File: rtl/vpl_page_addr.sv
module vpl_page_addr #(
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned ADDR_W = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W  = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_dr,
  input  logic              byte_last,
  output logic              write_req,
  output logic [ADDR_W-1:0] addr,
  output logic              full
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (capture_dr) cnt_q <= '0;
    else if (write_req)  cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    full      = (cnt_q == CNT_W'(PAGE_BYTES));
    write_req = byte_last && !full;
    addr      = cnt_q[ADDR_W-1:0];
  end

  // R7
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PAGE_BYTES));

  // R4
  count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (write_req && !capture_dr) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/vpl_wr_port.sv
module vpl_wr_port
  import vpl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  byte_t             req_data,
  output logic              wvalid,
  input  logic              wready,
  output logic [ADDR_W-1:0] waddr,
  output byte_t             wdata
);
  logic slot_free;

  assign slot_free = !wvalid || wready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wvalid <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
    end else if (req && slot_free) begin
      wvalid <= 1'b1;
      waddr  <= req_addr;
      wdata  <= req_data;
    end else if (wvalid && wready) begin
      wvalid <= 1'b0;
    end
  end

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> wvalid && $stable(waddr) && $stable(wdata));
endmodule

// File: rtl/vpl_page_load_dr.sv
module vpl_page_load_dr
  import vpl_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned ADDR_W = $clog2(PAGE_BYTES)
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              pb_valid,
  input  logic              pb_ready,
  output logic [ADDR_W-1:0] pb_addr,
  output logic [BYTE_W-1:0] pb_data
);
  byte_t             next_byte;
  logic              byte_last;
  logic              write_req;
  logic [ADDR_W-1:0] cur_addr;
  logic              page_full;

  vpl_deser u_deser (
    .clk        (tck),
    .rst_n      (rst_n),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .tdi        (tdi),
    .next_byte  (next_byte),
    .byte_last  (byte_last),
    .tdo        (tdo)
  );

  vpl_page_addr #(.PAGE_BYTES(PAGE_BYTES)) u_addr (
    .clk        (tck),
    .rst_n      (rst_n),
    .capture_dr (capture_dr),
    .byte_last  (byte_last),
    .write_req  (write_req),
    .addr       (cur_addr),
    .full       (page_full)
  );

  vpl_wr_port #(.ADDR_W(ADDR_W)) u_wr (
    .clk      (tck),
    .rst_n    (rst_n),
    .req      (write_req),
    .req_addr (cur_addr),
    .req_data (next_byte),
    .wvalid   (pb_valid),
    .wready   (pb_ready),
    .waddr    (pb_addr),
    .wdata    (pb_data)
  );

  // R6
  no_write_without_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !shift_dr |=> !$rose(pb_valid));

  // R6
  update_moves_nothing_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (update_dr && !shift_dr) |=> !$rose(pb_valid));

  // R7
  full_page_silent_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (page_full && !capture_dr && !pb_valid) |=> !pb_valid);
endmodule

// File: tb/test_vpl_page_load_dr.sv
module test_vpl_page_load_dr;
  localparam int unsigned PAGE = 256;
  localparam int unsigned AW = $clog2(PAGE);

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0, pb_ready = 0;
  logic tdo, pb_valid;
  logic [AW-1:0] pb_addr;
  logic [7:0] pb_data;

  always #5 tck = ~tck;

  vpl_page_load_dr #(.PAGE_BYTES(PAGE)) i_vpl_page_load_dr (
    .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .pb_valid(pb_valid),
    .pb_ready(pb_ready), .pb_addr(pb_addr), .pb_data(pb_data)
  );

  int checks = 0, errors = 0, accepted = 0;
  bit done = 0;
  string cur_req = "R3";

  // model state
  bit        m_v = 0;
  int        m_a = 0, m_cnt = 0, m_bit = 0;
  logic [7:0] m_d = 0, m_sr = 0;

  function automatic logic [7:0] shifted(input logic d, input logic [7:0] sr);
    return {d, sr[7:1]};
  endfunction

  function automatic bit completes(input logic cap, input logic sh, input int bitc, input int cnt);
    return !cap && sh && (bitc == 7) && (cnt < PAGE);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic cap, input logic sh, input logic up, input logic d, input logic rdy);
    logic [7:0] nb;
    bit dn;
    capture_dr = cap; shift_dr = sh; update_dr = up; tdi = d; pb_ready = rdy;
    nb = shifted(d, m_sr);
    dn = completes(cap, sh, m_bit, m_cnt);
    if (m_v && rdy) accepted++;
    if (dn && (!m_v || rdy)) begin
      m_v = 1; m_a = m_cnt; m_d = nb;
    end else if (m_v && rdy) m_v = 0;
    if (cap) begin
      m_bit = 0; m_sr = 0; m_cnt = 0;
    end else if (sh) begin
      m_sr = nb; m_bit = (m_bit + 1) % 8;
      if (dn) m_cnt++;
    end
    @(posedge tck);
    @(negedge tck);
    check(cur_req, "pb_valid", int'(pb_valid), int'(m_v));
    if (m_v) begin
      check("R4", "pb_addr", int'(pb_addr), m_a);
      check("R2", "pb_data", int'(pb_data), int'(m_d));
    end
    check("R9", "tdo", int'(tdo), int'(m_sr[0]));
  endtask

  task automatic shift_byte(input logic [7:0] b, input logic rdy);
    for (int i = 0; i < 8; i++) step(0, 1, 0, b[i], rdy);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge tck);
    // R1: reset state
    check("R1", "pb_valid in reset", int'(pb_valid), 0);
    check("R1", "tdo in reset", int'(tdo), 0);
    rst_n = 1'b1;
    @(negedge tck);
    check("R1", "pb_valid after reset", int'(pb_valid), 0);

    // R1, R2, R3: first byte straight after reset goes to address 0
    cur_req = "R1";
    shift_byte(8'hA5, 1);
    check("R2", "first byte value", int'(pb_data), 8'hA5);
    check("R1", "first byte address", int'(pb_addr), 0);
    cur_req = "R4";
    shift_byte(8'h3C, 1);
    check("R4", "second byte address", int'(pb_addr), 1);
    step(0, 0, 0, 0, 1);

    // R6: no shift edges, random tdi, update pulses
    cur_req = "R6";
    for (int i = 0; i < 40; i++) step(0, 0, (i % 5) == 0, 1'($urandom), 1);
    check("R6", "no write while idle", int'(pb_valid), 0);

    // R5: capture mid-byte discards partial bits
    cur_req = "R5";
    for (int i = 0; i < 5; i++) step(0, 1, 0, 1, 1);
    step(1, 0, 0, 0, 1);
    shift_byte(8'h81, 1);
    check("R5", "address after capture", int'(pb_addr), 0);
    check("R5", "data after capture", int'(pb_data), 8'h81);

    // R8: back-pressure, second and third bytes dropped
    cur_req = "R8";
    step(1, 0, 0, 0, 1);
    shift_byte(8'h11, 0);
    shift_byte(8'h22, 0);
    shift_byte(8'h33, 0);
    check("R8", "held address", int'(pb_addr), 0);
    check("R8", "held data", int'(pb_data), 8'h11);
    shift_byte(8'h44, 1);
    check("R8", "address after drops", int'(pb_addr), 3);

    // R7: full page plus overrun
    cur_req = "R7";
    step(0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    accepted = 0;
    for (int i = 0; i < PAGE * 8 + 40; i++) step(0, 1, 0, 1'($urandom), 1);
    step(0, 0, 0, 0, 1);
    check("R7", "writes in one page", accepted, PAGE);

    // random mix
    cur_req = "R3";
    for (int i = 0; i < 20000; i++) begin
      int r = int'($urandom_range(0, 99));
      step(r < 2, (r >= 2) && (r < 85), (r >= 85) && (r < 90), 1'($urandom), ($urandom_range(0, 3) != 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule